// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port with Peripheral Direction Override

This block controls a group of general-purpose pins from a small synchronous register bus. Software writes an output latch, a direction mask and a drive-strength mask, and reads back the pin levels through a two-flop input synchronizer. The block drives the pad controls directly: output enable, output value and a reduced-drive select for each pin.

On-chip peripherals can take over the direction of some pins. Two serial units each force fixed pins to input or to output while they are enabled. A routed unit claims a parameter-selected group of pins and sets their direction from its own per-pin direction signal. When several units claim the same pin, a fixed priority applies: serial unit A first, then serial unit B, then the routed unit, then the software direction. The software direction register is never changed by an override. When the override ends, control returns to the stored bits.

Top module: `gpio_port_ovr`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero. `pad_oe`, `pad_out` and `pad_rdrv` are all zero, so every pin is an input at full drive.
- R2: The direction register is at address 1 and can be read and written. A bit of 1 makes its pin an output. With no peripheral enabled, `pad_oe` equals this register.
- R3: The output latch is written at address 0, and `pad_out` always equals the latch.
- R4: While `ser_a_en` is high, pin 0 is forced to input and pin 1 is forced to output.
- R5: While `ser_b_en` is high, pin 2 is forced to input.
- R6: While `rte_en` is high, each pin in the routed group (default pins 1 to 4) takes its direction from the matching bit of `rte_dir`.
- R7: When claims overlap, the priority is serial A, then serial B, then routed, then the software direction bit.
- R8: An override never modifies the stored direction bits. Software may still write them during an override. When the override ends, `pad_oe` follows the stored bits again.
- R9: The input register is at address 3 and is read-only. A pad level change appears on `bus_rdata` on the third rising edge after the change: two synchronizer stages, then the registered read port.
- R10: Reading address 0 returns, for each pin, the output latch bit if the pin's effective direction is output, and the synchronized pin level otherwise.
- R11: The reduced-drive register is at address 2, resets to zero, and can be read and written at any time. `pad_rdrv` equals it.
- R12: Addresses 4 to 7 read as zero. Writes to those addresses and to the input register change no state.
- R13: Read data is registered. `bus_rdata` reflects the address presented at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ser_a_en | input | 1 | Serial unit A enable (pin 0 in, pin 1 out) |
| ser_b_en | input | 1 | Serial unit B enable (pin 2 in) |
| rte_en | input | 1 | Routed unit enable |
| rte_dir | input | 8 | Routed unit per-pin direction, 1 = output |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_rdrv | output | 8 | Pad reduced-drive selects |

## Verification
The bench uses the default parameters: eight pins, a three-bit address, serial A claiming pins 0 and 1, serial B claiming pin 2, and a routed group on pins 1 to 4. The routed group overlaps both serial units, so every level of the priority chain can be reached. This includes the case where a serial unit and the routed unit disagree on the same pin. The two-stage synchronizer default makes the exact readback latency visible as a cycle count.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int REG_DATA  = 0;
  localparam int REG_DIR   = 1;
  localparam int REG_DRIVE = 2;
  localparam int REG_INPUT = 3;

  // Priority resolution for one pin: serial A, serial B, routed, software.
  function automatic logic pin_dir(
    input logic sw_bit,
    input logic a_claim, input logic a_out,
    input logic b_claim, input logic b_out,
    input logic r_claim, input logic r_bit);
    logic d;
    if (a_claim)      d = a_out;
    else if (b_claim) d = b_out;
    else if (r_claim) d = r_bit;
    else              d = sw_bit;
    return d;
  endfunction

  // Data-register readback: the latch for output pins, the pin level for input pins.
  function automatic logic readback_bit(input logic latch, input logic lvl, input logic dir);
    return dir ? latch : lvl;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int PW     = 8,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] d,
  output logic [PW-1:0] q
);
  logic [PW-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_dir_arb.sv
module gpio_dir_arb
  import gpio_pkg::*;
#(
  parameter int          PW    = 8,
  parameter logic [PW-1:0] A_IN  = 'h01,
  parameter logic [PW-1:0] A_OUT = 'h02,
  parameter logic [PW-1:0] B_IN  = 'h04,
  parameter logic [PW-1:0] B_OUT = 'h00,
  parameter logic [PW-1:0] R_GRP = 'h1E
) (
  input  logic [PW-1:0] sw_dir,
  input  logic          a_en,
  input  logic          b_en,
  input  logic          r_en,
  input  logic [PW-1:0] r_dir,
  output logic [PW-1:0] eff_dir,
  output logic [PW-1:0] ovr_mask
);
  localparam logic [PW-1:0] A_CLAIM = A_IN | A_OUT;
  localparam logic [PW-1:0] B_CLAIM = B_IN | B_OUT;

  generate
    for (genvar p = 0; p < PW; p++) begin : g_pin
      logic ac, bc, rc;
      assign ac = a_en & A_CLAIM[p];
      assign bc = b_en & B_CLAIM[p];
      assign rc = r_en & R_GRP[p];
      assign eff_dir[p]  = pin_dir(sw_dir[p], ac, A_OUT[p], bc, B_OUT[p], rc, r_dir[p]);
      assign ovr_mask[p] = ac | bc | rc;
    end
  endgenerate
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int PW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [PW-1:0] wdata,
  output logic [PW-1:0] rdata,
  input  logic [PW-1:0] eff_dir,
  input  logic [PW-1:0] sync_in,
  output logic [PW-1:0] latch_q,
  output logic [PW-1:0] dir_q,
  output logic [PW-1:0] drv_q,
  output logic          wr_data,
  output logic          wr_dir,
  output logic          wr_drv
);
  localparam logic [AW-1:0] A_DATA  = AW'(REG_DATA);
  localparam logic [AW-1:0] A_DIR   = AW'(REG_DIR);
  localparam logic [AW-1:0] A_DRIVE = AW'(REG_DRIVE);
  localparam logic [AW-1:0] A_INPUT = AW'(REG_INPUT);

  logic [PW-1:0] data_view;
  logic [PW-1:0] rd_mux;

  assign wr_data = we && (addr == A_DATA);
  assign wr_dir  = we && (addr == A_DIR);
  assign wr_drv  = we && (addr == A_DRIVE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
      drv_q   <= '0;
    end else begin
      if (wr_data) latch_q <= wdata;
      if (wr_dir)  dir_q   <= wdata;
      if (wr_drv)  drv_q   <= wdata;
    end
  end

  generate
    for (genvar p = 0; p < PW; p++) begin : g_view
      assign data_view[p] = readback_bit(latch_q[p], sync_in[p], eff_dir[p]);
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_DATA:  rd_mux = data_view;
      A_DIR:   rd_mux = dir_q;
      A_DRIVE: rd_mux = drv_q;
      A_INPUT: rd_mux = sync_in;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_port_ovr.sv
module gpio_port_ovr #(
  parameter int            PW          = 8,
  parameter int            AW          = 3,
  parameter int            SYNC_STAGES = 2,
  parameter logic [PW-1:0] A_IN        = 'h01,
  parameter logic [PW-1:0] A_OUT       = 'h02,
  parameter logic [PW-1:0] B_IN        = 'h04,
  parameter logic [PW-1:0] B_OUT       = 'h00,
  parameter logic [PW-1:0] R_GRP       = 'h1E
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [PW-1:0] bus_wdata,
  output logic [PW-1:0] bus_rdata,
  input  logic          ser_a_en,
  input  logic          ser_b_en,
  input  logic          rte_en,
  input  logic [PW-1:0] rte_dir,
  input  logic [PW-1:0] pad_in,
  output logic [PW-1:0] pad_out,
  output logic [PW-1:0] pad_oe,
  output logic [PW-1:0] pad_rdrv
);
  logic [PW-1:0] sync_in;
  logic [PW-1:0] eff_dir;
  logic [PW-1:0] ovr_mask;
  logic [PW-1:0] latch_q, dir_q, drv_q;
  logic          wr_data, wr_dir, wr_drv;

  gpio_sync #(.PW(PW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(sync_in)
  );

  gpio_dir_arb #(
    .PW(PW), .A_IN(A_IN), .A_OUT(A_OUT), .B_IN(B_IN), .B_OUT(B_OUT), .R_GRP(R_GRP)
  ) u_arb (
    .sw_dir(dir_q), .a_en(ser_a_en), .b_en(ser_b_en), .r_en(rte_en),
    .r_dir(rte_dir), .eff_dir(eff_dir), .ovr_mask(ovr_mask)
  );

  gpio_regs #(.PW(PW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .rdata(bus_rdata), .eff_dir(eff_dir), .sync_in(sync_in),
    .latch_q(latch_q), .dir_q(dir_q), .drv_q(drv_q),
    .wr_data(wr_data), .wr_dir(wr_dir), .wr_drv(wr_drv)
  );

  assign pad_out  = latch_q;
  assign pad_oe   = eff_dir;
  assign pad_rdrv = drv_q;
endmodule

// File: rtl/gpio_port_ovr_chk.sv
module gpio_port_ovr_chk #(
  parameter int            PW    = 8,
  parameter int            AW    = 3,
  parameter logic [PW-1:0] A_IN  = 'h01,
  parameter logic [PW-1:0] A_OUT = 'h02,
  parameter logic [PW-1:0] B_IN  = 'h04,
  parameter logic [PW-1:0] B_OUT = 'h00,
  parameter logic [PW-1:0] R_GRP = 'h1E
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_we,
  input logic [PW-1:0] bus_wdata,
  input logic [PW-1:0] bus_rdata,
  input logic          ser_a_en,
  input logic          ser_b_en,
  input logic          rte_en,
  input logic [PW-1:0] rte_dir,
  input logic [PW-1:0] pad_in,
  input logic [PW-1:0] pad_out,
  input logic [PW-1:0] pad_oe,
  input logic [PW-1:0] pad_rdrv,
  input logic [PW-1:0] dir_q,
  input logic [PW-1:0] sync_in,
  input logic          wr_dir,
  input logic          wr_drv
);
  localparam logic [PW-1:0] A_CLAIM = A_IN | A_OUT;
  localparam logic [PW-1:0] B_CLAIM = B_IN | B_OUT;

  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n)                  since_rst <= '0;
    else if (since_rst != 2'd3)  since_rst <= since_rst + 2'd1;
  end

  p_reset_r1: assert property (@(posedge clk) !rst_n |=> (pad_oe == '0 && pad_out == '0 && pad_rdrv == '0 && bus_rdata == '0));

  p_free_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_a_en && !ser_b_en && !rte_en) |-> pad_oe == dir_q);

  p_ser_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ser_a_en |-> ((pad_oe & A_IN) == '0 && (pad_oe & A_OUT) == A_OUT));

  p_ser_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ser_b_en |-> ((pad_oe & B_IN & ~A_CLAIM) == '0 || ser_a_en));

  p_routed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rte_en && !ser_a_en && !ser_b_en) |-> ((pad_oe & R_GRP) == (rte_dir & R_GRP)));

  p_keep_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_dir) |=> $stable(dir_q));

  p_sync_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> sync_in == $past(pad_in, 2));

  p_drive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drv |=> pad_rdrv == $past(bus_wdata));

  p_unmapped_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > AW'(3)) |=> bus_rdata == '0);

  p_priority_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_b_en && rte_en && !ser_a_en) |-> ((pad_oe & B_IN & R_GRP) == '0));
endmodule

bind gpio_port_ovr gpio_port_ovr_chk #(
  .PW(PW), .AW(AW), .A_IN(A_IN), .A_OUT(A_OUT), .B_IN(B_IN), .B_OUT(B_OUT), .R_GRP(R_GRP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .ser_a_en(ser_a_en), .ser_b_en(ser_b_en), .rte_en(rte_en),
  .rte_dir(rte_dir), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
  .pad_rdrv(pad_rdrv), .dir_q(dir_q), .sync_in(sync_in), .wr_dir(wr_dir), .wr_drv(wr_drv)
);

// File: tb/gpio_port_ovr_tb.sv
module gpio_port_ovr_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ser_a_en = 1'b0, ser_b_en = 1'b0, rte_en = 1'b0;
  logic [7:0] rte_dir = '0, pad_in = '0;
  logic [7:0] pad_out, pad_oe, pad_rdrv;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // bench model of software state
  logic [7:0] m_lat = '0, m_dir = '0, m_drv = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_ovr u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ser_a_en(ser_a_en),
    .ser_b_en(ser_b_en), .rte_en(rte_en), .rte_dir(rte_dir), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_rdrv(pad_rdrv)
  );

  // Expected direction: walk the claimants from lowest to highest priority,
  // so a later claim overwrites an earlier one.
  function automatic logic [7:0] exp_oe(logic [7:0] sw, logic a, logic b, logic r, logic [7:0] rd);
    logic [7:0] e = sw;
    if (r) e = (e & ~8'h1E) | (rd & 8'h1E);
    if (b) e = e & ~8'h04;
    if (a) e = (e & ~8'h03) | 8'h02;
    return e;
  endfunction

  function automatic logic [7:0] exp_data(logic [7:0] lat, logic [7:0] lvl, logic [7:0] oe);
    return (lat & oe) | (lvl & ~oe);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    if (a == 3'd0) m_lat = d;
    if (a == 3'd1) m_dir = d;
    if (a == 3'd2) m_drv = d;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic settle_pads(logic [7:0] v);
    @(negedge clk);
    pad_in = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 oe", pad_oe, 8'h00);
    chk("R1 out", pad_out, 8'h00);
    chk("R1 rdrv", pad_rdrv, 8'h00);
    rd(3'd1, v); chk("R1 dir", v, 8'h00);
    rd(3'd2, v); chk("R1 drv", v, 8'h00);

    // R2 / R3 / R11 basic registers
    wr(3'd1, 8'hA6); #1; chk("R2 oe", pad_oe, 8'hA6);
    rd(3'd1, v); chk("R2 read", v, 8'hA6);
    wr(3'd0, 8'h5C); #1; chk("R3 out", pad_out, 8'h5C);
    wr(3'd2, 8'hF0); #1; chk("R11 rdrv", pad_rdrv, 8'hF0);
    rd(3'd2, v); chk("R11 read", v, 8'hF0);

    // R4, R5, R6
    wr(3'd1, 8'hFF);
    ser_a_en = 1'b1; #1; chk("R4 serial A", pad_oe, 8'hFE);
    ser_a_en = 1'b0; wr(3'd1, 8'h00);
    ser_a_en = 1'b1; #1; chk("R4 serial A low", pad_oe, 8'h02);
    ser_a_en = 1'b0; wr(3'd1, 8'hFF);
    ser_b_en = 1'b1; #1; chk("R5 serial B", pad_oe, 8'hFB);
    ser_b_en = 1'b0; wr(3'd1, 8'h00);
    rte_en = 1'b1; rte_dir = 8'hFF; #1; chk("R6 routed", pad_oe, 8'h1E);
    rte_dir = 8'h0A; #1; chk("R6 routed mix", pad_oe, 8'h0A);

    // R7 priority
    ser_a_en = 1'b1; rte_dir = 8'h00; #1; chk("R7 A over routed", pad_oe, 8'h02);
    ser_a_en = 1'b0; ser_b_en = 1'b1; rte_dir = 8'hFF; #1; chk("R7 B over routed", pad_oe, 8'h1A);
    ser_a_en = 1'b1; #1; chk("R7 all", pad_oe, 8'h1A);
    ser_a_en = 1'b0; ser_b_en = 1'b0; rte_en = 1'b0; rte_dir = 8'h00;

    // R8 stored bits kept
    wr(3'd1, 8'h01);
    ser_a_en = 1'b1;
    rd(3'd1, v); chk("R8 dir kept", v, 8'h01);
    wr(3'd1, 8'hF1); #1; chk("R8 write during ovr", pad_oe, 8'hF2);
    ser_a_en = 1'b0; #1; chk("R8 release", pad_oe, 8'hF1);
    rd(3'd1, v); chk("R8 dir after", v, 8'hF1);

    // R9 latency, R13 registered read
    wr(3'd1, 8'h00);
    settle_pads(8'h00);
    @(negedge clk); bus_addr = 3'd3; pad_in = 8'hA5;
    @(negedge clk); chk("R9 edge1", bus_rdata, 8'h00);
    @(negedge clk); chk("R9 edge2", bus_rdata, 8'h00);
    @(negedge clk); chk("R9 edge3", bus_rdata, 8'hA5);
    bus_addr = 3'd2; #1; chk("R13 no comb read", bus_rdata, 8'hA5);

    // R10 data readback
    wr(3'd1, 8'h0F); wr(3'd0, 8'hC3);
    settle_pads(8'h3C);
    rd(3'd0, v); chk("R10 free", v, 8'h33);
    ser_a_en = 1'b1;
    rd(3'd0, v); chk("R10 override", v, 8'h32);
    ser_a_en = 1'b0;

    // R12 unmapped and read-only
    for (int a = 4; a < 8; a++) begin
      wr(3'(a), 8'hFF);
      rd(3'(a), v); chk("R12 unmapped", v, 8'h00);
    end
    wr(3'd3, 8'hFF);
    rd(3'd3, v); chk("R12 input ro", v, 8'h3C);
    rd(3'd1, v); chk("R12 dir untouched", v, 8'h0F);
    rd(3'd2, v); chk("R12 drv untouched", v, 8'hF0);
    #1; chk("R12 out untouched", pad_out, 8'hC3);

    // random phase
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 300; i++) begin
      logic [7:0] lvl, e;
      logic [2:0] ra;
      ra = 3'($urandom_range(0, 2));
      wr(ra, 8'($urandom));
      ser_a_en = 1'($urandom); ser_b_en = 1'($urandom); rte_en = 1'($urandom);
      rte_dir = 8'($urandom);
      lvl = 8'($urandom);
      settle_pads(lvl);
      e = exp_oe(m_dir, ser_a_en, ser_b_en, rte_en, rte_dir);
      chk("R7 random oe", pad_oe, e);
      chk("R3 random out", pad_out, m_lat);
      chk("R11 random rdrv", pad_rdrv, m_drv);
      rd(3'd0, v); chk("R10 random data", v, exp_data(m_lat, lvl, e));
      rd(3'd3, v); chk("R9 random input", v, lvl);
      rd(3'd1, v); chk("R8 random dir", v, m_dir);
    end

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    ser_a_en = 1'b0; ser_b_en = 1'b0; rte_en = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R1 re-reset oe", pad_oe, 8'h00);
    chk("R1 re-reset rdrv", pad_rdrv, 8'h00);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule